// File: doc/BRIEF.md
# Network Controller Interrupt Status Aggregator

This block gathers event pulses from the receive and transmit engines of a network controller into a 32-bit main status register. It also gathers management-interface events into a 16-bit secondary status register. Each register has a mask of its own. The secondary register, after masking, folds into a single summary bit of the main status. The unmasked main status drives one level-sensitive interrupt line. Software reads the main status to find out which engine raised the interrupt. That read clears the engine events, but it leaves the summary bit alone: the summary bit only drops when the secondary status is read or masked.

The block also holds a reset-request register for the two engines. Software sets a request bit, the bit drives the matching engine, and it reads back as zero once the engine reports that its reset is complete. All registers sit behind a simple word-wide request port. Read data appears one cycle after the request.

Register offsets: 0x000 engine reset, 0x100 main status, 0x104 main mask, 0x108 second name for the main status, 0x10C second name for the main mask, 0x200 management status, 0x204 management mask.

Top module: `net_irq_agg`

## Requirements
- R1: After reset the main mask reads 0xFF7FFFFF, the management mask reads 0x0000FFFF, and the main status, management status, reset register, `irq_o` and `rdata_o` are all zero.
- R2: A one-cycle pulse on `rx_done_i`, `rx_nodesc_i`, `tx_desc_i` or `tx_idle_i` sets main status bit 16, 17, 24 or 25 respectively, and the bit stays set until it is cleared.
- R3: A read of the main status returns its value and then clears every stored bit. An event pulse in the same cycle as the read wins, so that bit stays set after the read.
- R4: Main status bit 23 reads as 1 whenever (management status AND NOT management mask) is nonzero, and reads as 0 otherwise. A main status read does not clear it.
- R5: A pulse on bit i of `mgmt_evt_i` sets bit i of the management status. A read of the management status returns the value and clears it, except that a pulse in the same cycle wins. Writes to the management mask store the low 16 bits.
- R6: `irq_o` goes high one cycle after any bit of (main status AND NOT main mask) is set, and goes low one cycle after none is set. A mask bit of 1 disables the matching status bit.
- R7: Offset 0x108 reads and writes the main status exactly as 0x100 does, and offset 0x10C reads and writes the main mask exactly as 0x104 does.
- R8: Writing 1 to bit 0 (transmit) or bit 1 (receive) of the reset register raises `tx_rst_req_o` or `rx_rst_req_o`. The bit reads back as 1 until a pulse on `tx_rst_done_i` or `rx_rst_done_i` clears it. A write in the same cycle as the done pulse wins.
- R9: `rdata_o` holds the data of the last read from the cycle after that read. Reads of an unmapped offset return 0, and writes to an unmapped offset change no register.
- R10: A write to the main status replaces its stored bits with the write data, except bit 23, which keeps following R4. Event pulses in the same cycle are still ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after a read |
| rx_done_i | input | 1 | Receive frame delivered pulse |
| rx_nodesc_i | input | 1 | No receive descriptor pulse |
| tx_desc_i | input | 1 | Transmit descriptor consumed pulse |
| tx_idle_i | input | 1 | Transmit queue drained pulse |
| mgmt_evt_i | input | MGW | Management-interface event pulses |
| tx_rst_done_i | input | 1 | Transmit engine reset complete pulse |
| rx_rst_done_i | input | 1 | Receive engine reset complete pulse |
| tx_rst_req_o | output | 1 | Transmit engine reset request |
| rx_rst_req_o | output | 1 | Receive engine reset request |
| irq_o | output | 1 | Level-sensitive interrupt, registered |

## Verification
The assertions assume that event and done inputs are clean synchronous levels sampled at each edge. They also assume that a register access presents one offset and one direction per cycle, so that a read-clear and a software write never reach the same register in one cycle. The stimulus drives every input half a cycle away from the sampling edge and issues at most one access per cycle. It freely lets event pulses coincide with reads and writes of the register they touch, so that the set-wins ordering is exercised rather than avoided.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NEVT    = 4;
  localparam int SUM_BIT = 23;
  // event input order: rx_done, rx_nodesc, tx_desc, tx_idle
  localparam int EVT_POS [NEVT] = '{16, 17, 24, 25};

  localparam logic [11:0] OFF_RST      = 12'h000;
  localparam logic [11:0] OFF_STAT     = 12'h100;
  localparam logic [11:0] OFF_MASK     = 12'h104;
  localparam logic [11:0] OFF_STAT_ALT = 12'h108;
  localparam logic [11:0] OFF_MASK_ALT = 12'h10C;
  localparam logic [11:0] OFF_GSTAT    = 12'h200;
  localparam logic [11:0] OFF_GMASK    = 12'h204;

  localparam logic [31:0] MASK_RST  = 32'hFF7F_FFFF;

  typedef struct packed {
    logic rst;
    logic stat;
    logic mask;
    logic gstat;
    logic gmask;
  } reg_sel_t;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output reg_sel_t      rd_o,
  output reg_sel_t      wr_o
);
  reg_sel_t sel;

  always_comb begin
    sel = '0;
    if (addr_i == AW'(OFF_RST))                                    sel.rst   = 1'b1;
    if (addr_i == AW'(OFF_STAT) || addr_i == AW'(OFF_STAT_ALT))    sel.stat  = 1'b1;
    if (addr_i == AW'(OFF_MASK) || addr_i == AW'(OFF_MASK_ALT))    sel.mask  = 1'b1;
    if (addr_i == AW'(OFF_GSTAT))                                  sel.gstat = 1'b1;
    if (addr_i == AW'(OFF_GMASK))                                  sel.gmask = 1'b1;
  end

  assign rd_o = (req_i && !we_i) ? sel : '0;
  assign wr_o = (req_i &&  we_i) ? sel : '0;

  // R7: second names reach the same registers
  p_alias_stat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == AW'(OFF_STAT_ALT)) |-> (rd_o.stat || wr_o.stat));
  p_alias_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == AW'(OFF_MASK_ALT)) |-> (rd_o.mask || wr_o.mask));
  p_one_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, wr_o}));
endmodule

// File: rtl/irq_agg_mgmt.sv
module irq_agg_mgmt #(
  parameter int MGW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [MGW-1:0] evt_i,
  input  logic           rd_i,
  input  logic           wr_mask_i,
  input  logic [MGW-1:0] wdata_i,
  output logic [MGW-1:0] stat_o,
  output logic [MGW-1:0] mask_o,
  output logic           summary_o
);
  logic [MGW-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (rd_i ? '0 : stat_q) | evt_i;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign stat_o    = stat_q;
  assign mask_o    = mask_q;
  assign summary_o = |(stat_q & ~mask_q);

  p_rdclr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && evt_i == '0) |=> stat_q == '0);
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_agg_main.sv
module irq_agg_main
  import irq_agg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] evt_i,
  input  logic            rd_i,
  input  logic            wr_stat_i,
  input  logic            wr_mask_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            summary_i,
  output logic [DW-1:0]   stat_o,
  output logic [DW-1:0]   mask_o
);
  localparam logic [DW-1:0] SUM_M = DW'(1) << SUM_BIT;

  logic [DW-1:0] stat_q, mask_q, evt_vec, base;

  always_comb begin
    evt_vec = '0;
    for (int i = 0; i < NEVT; i++) evt_vec[EVT_POS[i]] = evt_i[i];
  end

  always_comb begin
    base = stat_q;
    if (wr_stat_i)  base = wdata_i & ~SUM_M;
    else if (rd_i)  base = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= DW'(MASK_RST);
    end else begin
      stat_q <= base | evt_vec;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q | (summary_i ? SUM_M : '0);
  assign mask_o = mask_q;

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    p_evt_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> stat_q[EVT_POS[g]]);
  end

  p_rdclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_stat_i && evt_i == '0) |=> stat_q == '0);
  p_summary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[SUM_BIT] == summary_i);
endmodule

// File: rtl/irq_agg_rstreq.sv
module irq_agg_rstreq #(
  parameter int NENG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NENG-1:0] wbits_i,
  input  logic [NENG-1:0] done_i,
  output logic [NENG-1:0] req_o
);
  logic [NENG-1:0] req_q;

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   req_q[e] <= 1'b0;
      else if (wr_i && wbits_i[e])   req_q[e] <= 1'b1;
      else if (done_i[e])            req_q[e] <= 1'b0;
    end

    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q[e] && !done_i[e]) |=> req_q[e]);
    p_done_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[e] && !(wr_i && wbits_i[e])) |=> !req_q[e]);
  end

  assign req_o = req_q;
endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int MGW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           rx_done_i,
  input  logic           rx_nodesc_i,
  input  logic           tx_desc_i,
  input  logic           tx_idle_i,
  input  logic [MGW-1:0] mgmt_evt_i,
  input  logic           tx_rst_done_i,
  input  logic           rx_rst_done_i,
  output logic           tx_rst_req_o,
  output logic           rx_rst_req_o,
  output logic           irq_o
);
  reg_sel_t       rd_sel, wr_sel;
  logic [DW-1:0]  stat_eff, mask, rd_d, rdata_q;
  logic [MGW-1:0] gstat, gmask;
  logic           summary, irq_q;
  logic [1:0]     rst_req;

  irq_agg_decode #(.AW(AW)) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .rd_o(rd_sel), .wr_o(wr_sel)
  );

  irq_agg_mgmt #(.MGW(MGW)) u_mgmt (
    .clk_i, .rst_ni,
    .evt_i(mgmt_evt_i), .rd_i(rd_sel.gstat), .wr_mask_i(wr_sel.gmask),
    .wdata_i(wdata_i[MGW-1:0]),
    .stat_o(gstat), .mask_o(gmask), .summary_o(summary)
  );

  irq_agg_main #(.DW(DW)) u_main (
    .clk_i, .rst_ni,
    .evt_i({tx_idle_i, tx_desc_i, rx_nodesc_i, rx_done_i}),
    .rd_i(rd_sel.stat), .wr_stat_i(wr_sel.stat), .wr_mask_i(wr_sel.mask),
    .wdata_i, .summary_i(summary),
    .stat_o(stat_eff), .mask_o(mask)
  );

  irq_agg_rstreq #(.NENG(2)) u_rst (
    .clk_i, .rst_ni,
    .wr_i(wr_sel.rst), .wbits_i(wdata_i[1:0]),
    .done_i({rx_rst_done_i, tx_rst_done_i}), .req_o(rst_req)
  );

  always_comb begin
    rd_d = '0;
    if (rd_sel.rst)   rd_d = DW'(rst_req);
    if (rd_sel.stat)  rd_d = stat_eff;
    if (rd_sel.mask)  rd_d = mask;
    if (rd_sel.gstat) rd_d = DW'(gstat);
    if (rd_sel.gmask) rd_d = DW'(gmask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_q <= rd_d;
      irq_q <= |(stat_eff & ~mask);
    end
  end

  assign rdata_o      = rdata_q;
  assign irq_o        = irq_q;
  assign tx_rst_req_o = rst_req[0];
  assign rx_rst_req_o = rst_req[1];

  p_mask_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |=> !irq_o);
  p_unmapped_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && rd_sel == '0) |=> rdata_o == '0);
  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/net_irq_agg_test.sv
module net_irq_agg_test;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_done = 1'b0, rx_nodesc = 1'b0, tx_desc = 1'b0, tx_idle = 1'b0;
  logic [15:0] mgmt_evt = '0;
  logic        tx_done = 1'b0, rx_done_rst = 1'b0;
  logic        tx_req, rx_req, irq;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [31:0] m_st = '0, m_mk = 32'hFF7F_FFFF;
  logic [15:0] g_st = '0, g_mk = 16'hFFFF;
  logic        r_tx = 1'b0, r_rx = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  net_irq_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .rx_done_i(rx_done), .rx_nodesc_i(rx_nodesc), .tx_desc_i(tx_desc), .tx_idle_i(tx_idle),
    .mgmt_evt_i(mgmt_evt), .tx_rst_done_i(tx_done), .rx_rst_done_i(rx_done_rst),
    .tx_rst_req_o(tx_req), .rx_rst_req_o(rx_req), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] eff_stat();
    return m_st | (((g_st & ~g_mk) != 0) ? 32'h0080_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h000:          return {30'b0, r_rx, r_tx};
      12'h100, 12'h108: return eff_stat();
      12'h104, 12'h10C: return m_mk;
      12'h200:          return {16'b0, g_st};
      12'h204:          return {16'b0, g_mk};
      default:          return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h000:          return "R8";
      12'h100:          return "R3";
      12'h108, 12'h10C: return "R7";
      12'h104:          return "R6";
      12'h200:          return "R5";
      12'h204:          return "R5";
      default:          return "R9";
    endcase
  endfunction

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic cyc(string tag, bit rq, bit w, logic [11:0] a, logic [31:0] d,
                     logic [3:0] ev, logic [15:0] gev, logic [1:0] dn);
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [31:0] evv;
    req = rq; we = w; addr = a; wdata = d;
    {tx_idle, tx_desc, rx_nodesc, rx_done} = ev;
    mgmt_evt = gev; {rx_done_rst, tx_done} = dn;

    exp_rd  = model_read(a);
    exp_irq = |(eff_stat() & ~m_mk);
    evv = {6'b0, ev[3], ev[2], 6'b0, ev[1], ev[0], 16'b0};

    if (rq && w && (a == 12'h100 || a == 12'h108)) m_st = d & 32'hFF7F_FFFF;
    else if (rq && !w && (a == 12'h100 || a == 12'h108)) m_st = '0;
    m_st = m_st | evv;
    if (rq && w && (a == 12'h104 || a == 12'h10C)) m_mk = d;
    if (rq && !w && a == 12'h200) g_st = '0;
    g_st = g_st | gev;
    if (rq && w && a == 12'h204) g_mk = d[15:0];
    if (rq && w && a == 12'h000 && d[0]) r_tx = 1'b1; else if (dn[0]) r_tx = 1'b0;
    if (rq && w && a == 12'h000 && d[1]) r_rx = 1'b1; else if (dn[1]) r_rx = 1'b0;

    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; {tx_idle, tx_desc, rx_nodesc, rx_done} = '0;
    mgmt_evt = '0; {rx_done_rst, tx_done} = '0;

    chk("R6 irq", {31'b0, irq}, {31'b0, exp_irq});
    chk("R8 reqs", {30'b0, rx_req, tx_req}, {30'b0, r_rx, r_tx});
    if (rq && !w) chk(tag, rdata, exp_rd);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    cyc(tag, 1, 0, a, 32'h0, 4'h0, 16'h0, 2'b0);
  endtask
  task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
    cyc(tag, 1, 1, a, d, 4'h0, 16'h0, 2'b0);
  endtask
  task automatic idle(string tag, logic [3:0] ev, logic [15:0] gev, logic [1:0] dn);
    cyc(tag, 0, 0, 12'h0, 32'h0, ev, gev, dn);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 reqs", {30'b0, rx_req, tx_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 mask", 12'h104);
    rd("R1 gmask", 12'h204);
    rd("R1 stat", 12'h100);
    rd("R1 gstat", 12'h200);
    rd("R1 rst", 12'h000);

    // R2: each event sets its bit
    idle("R2", 4'b0001, 16'h0, 2'b0);
    idle("R2", 4'b0010, 16'h0, 2'b0);
    idle("R2", 4'b0100, 16'h0, 2'b0);
    idle("R2", 4'b1000, 16'h0, 2'b0);
    rd("R2 all events", 12'h100);
    // R3: cleared by read; set wins over read-clear
    rd("R3 cleared", 12'h100);
    cyc("R3 read with event", 1, 0, 12'h100, 32'h0, 4'b0001, 16'h0, 2'b0);
    rd("R3 event survived", 12'h100);

    // R4: summary from management status
    wr("R4 gmask", 12'h204, 32'h0000_FFFE);
    idle("R4", 4'h0, 16'h0001, 2'b0);
    idle("R4 irq up", 4'h0, 16'h0, 2'b0);
    rd("R4 summary", 12'h100);
    rd("R4 summary kept", 12'h100);
    idle("R4 masked evt", 4'h0, 16'h0100, 2'b0);
    // R5: read-clear of management status, set wins
    rd("R5 gstat", 12'h200);
    rd("R5 gstat cleared", 12'h200);
    cyc("R5 read with event", 1, 0, 12'h200, 32'h0, 4'h0, 16'h0002, 2'b0);
    rd("R5 event survived", 12'h200);
    rd("R4 summary gone", 12'h100);

    // R7 and R6: unmask tx_desc through second mask name
    wr("R7 mask alias", 12'h10C, 32'hFEFF_FFFF);
    rd("R7 mask via primary", 12'h104);
    idle("R6", 4'b0100, 16'h0, 2'b0);
    idle("R6 irq high", 4'h0, 16'h0, 2'b0);
    rd("R7 stat alias", 12'h108);
    idle("R6 irq low", 4'h0, 16'h0, 2'b0);
    idle("R6 irq low", 4'h0, 16'h0, 2'b0);
    wr("R6 mask all", 12'h104, 32'hFFFF_FFFF);
    idle("R6 masked", 4'b1111, 16'h0, 2'b0);
    idle("R6 masked", 4'h0, 16'h0, 2'b0);

    // R8: engine reset requests
    wr("R8 set both", 12'h000, 32'h3);
    rd("R8 readback", 12'h000);
    idle("R8 tx done", 4'h0, 16'h0, 2'b01);
    rd("R8 tx cleared", 12'h000);
    cyc("R8 write beats done", 1, 1, 12'h000, 32'h1, 4'h0, 16'h0, 2'b01);
    idle("R8 rx done", 4'h0, 16'h0, 2'b10);
    rd("R8 rx cleared", 12'h000);

    // R9: unmapped offsets
    wr("R9 unmapped write", 12'h3F0, 32'h0);
    rd("R9 mask intact", 12'h104);
    rd("R9 unmapped read", 12'h3F0);

    // R10: status write keeps summary separate
    wr("R10 stat write", 12'h100, 32'hFFFF_FFFF);
    rd("R10 stat readback", 12'h100);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] al [8];
      logic [11:0] a;
      logic [31:0] d;
      bit rq, w;
      al = '{12'h000, 12'h100, 12'h104, 12'h108, 12'h10C, 12'h200, 12'h204, 12'h3F0};
      a  = al[$urandom % 8];
      rq = ($urandom % 3) != 0;
      w  = ($urandom % 3) == 0;
      d  = $urandom;
      if ((a == 12'h104 || a == 12'h10C) && ($urandom % 2)) d = d | 32'hFC7C_FFFF;
      cyc(tag_of(a), rq, w, a, d,
          {($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0},
          (($urandom % 5) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0,
          {($urandom % 4) == 0, ($urandom % 4) == 0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule